// File: doc/BRIEF.md
# Global-Correlating Branch Direction Predictor

This block guesses the direction of conditional branches. A short shift register records the directions of the last two resolved branches, across all addresses. Four address bits choose one entry of a pattern table. Inside that entry, the recorded directions choose one of four small saturating counters, and the top bit of that counter is the guess. Two branches whose outcomes depend on each other can then be predicted correctly, which a predictor keyed on address alone cannot do.

The fetch side presents a PC on the lookup port. In the same cycle it reads back a taken/not-taken guess and the history value that formed the guess, and keeps that history with the branch. When the branch resolves, the back end presents the PC, the real direction and the kept history on the training port. Only the counter those values select is trained. The real direction is then shifted into the shared history.

Top module: `gcorr_predictor`

## Requirements
- R1: After a synchronous active-low reset, `pred_hist` is 0 and every counter holds the weakly-not-taken value 1, so `pred_taken` is 0 for every PC.
- R2: `pred_taken` is bit 1 of the counter at index `{pred_pc[5:2], pred_hist}` (6 bits, 64 counters), and is combinational from the stored state.
- R3: A trained counter moves up by one on a taken outcome (`upd_taken`=1) and stays at 3 once it is there.
- R4: A trained counter moves down by one on a not-taken outcome and stays at 0 once it is there.
- R5: A training event changes only the counter at index `{upd_pc[5:2], upd_hist}`. The other three counters of that entry and all other entries keep their values.
- R6: Each training event updates `pred_hist` at the next clock edge to `{old pred_hist[0], upd_taken}`.
- R7: Training uses the supplied `upd_hist`, not the current value of `pred_hist`.
- R8: A training event in the same cycle as a lookup does not change that cycle's `pred_taken` or `pred_hist`. It is seen from the next cycle on.
- R9: While `upd_valid` is 0, `upd_pc`, `upd_taken` and `upd_hist` have no effect on any counter or on `pred_hist`.
- R10: PC bits outside [5:2] have no effect on either port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pred_pc | input | 32 | PC of the branch being looked up |
| pred_taken | output | 1 | Guessed direction, 1 = taken |
| pred_hist | output | 2 | Current shared history; bit 0 is the newest outcome |
| upd_valid | input | 1 | A branch resolved this cycle |
| upd_pc | input | 32 | PC of the resolved branch |
| upd_taken | input | 1 | Real direction, 1 = taken |
| upd_hist | input | 2 | History that was returned with this branch's guess |

## Verification
Lookup and training can occur in the same cycle, and they can even select the same counter. The stimulus does this on purpose. It trains an index while looking it up, and it trains with a history that differs from the live one. A scoreboard model applies each training step only after it has recorded the expected answer for that cycle. Any leak of the new counter or history into the current cycle's guess therefore shows up as a mismatch. Idle cycles with junk on the training port and PCs with noisy upper bits check the cases where an input must have no effect.

// File: rtl/gcp_pkg.sv
// Shared definitions for the global-correlating predictor.
// Assumes: nothing beyond IEEE 1800-2017.
package gcp_pkg;

    // Default geometry of the predictor
    localparam int unsigned GCP_PC_W      = 32;
    localparam int unsigned GCP_IDX_LSB   = 2;
    localparam int unsigned GCP_ADDR_BITS = 4;
    localparam int unsigned GCP_HIST_W    = 2;
    localparam int unsigned GCP_CTR_W     = 2;

    // Branch direction encoding
    typedef enum logic {
        DIR_NOT_TAKEN = 1'b0,
        DIR_TAKEN     = 1'b1
    } gcp_dir_e;

endpackage

// File: rtl/gcp_index.sv
// Forms a counter index from a PC and a history value.
// Assumes: IDX_LSB >= 1 and IDX_LSB + ADDR_BITS < PC_W.
module gcp_index #(
    parameter int unsigned PC_W      = gcp_pkg::GCP_PC_W,
    parameter int unsigned IDX_LSB   = gcp_pkg::GCP_IDX_LSB,
    parameter int unsigned ADDR_BITS = gcp_pkg::GCP_ADDR_BITS,
    parameter int unsigned HIST_W    = gcp_pkg::GCP_HIST_W,
    localparam int unsigned IDX_W    = ADDR_BITS + HIST_W
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [HIST_W-1:0] hist,
    output logic [IDX_W-1:0]  idx
);

    localparam int unsigned ADDR_MSB = IDX_LSB + ADDR_BITS - 1;

    // PC bits that do not take part in the index
    logic pc_unused;

    // Address bits in the upper part, history in the lower part
    assign idx = {pc[ADDR_MSB:IDX_LSB], hist};

    // Gather the ignored bits in one place
    assign pc_unused = ^{pc[PC_W-1:ADDR_MSB+1], pc[IDX_LSB-1:0]};

endmodule

// File: rtl/gcp_ghr.sv
// Shared history shift register: on each training event the newest
// outcome enters bit 0 and the older bits move up by one place.
// Assumes: HIST_W >= 2.
module gcp_ghr #(
    parameter int unsigned HIST_W = gcp_pkg::GCP_HIST_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  gcp_pkg::gcp_dir_e dir,
    output logic [HIST_W-1:0] hist
);

    // Clear to all not-taken, shift in the resolved direction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '0;
        end else if (shift_en) begin
            hist <= {hist[HIST_W-2:0], dir == gcp_pkg::DIR_TAKEN};
        end
    end

endmodule

// File: rtl/gcp_sat_ctr.sv
// One saturating up/down counter whose MSB is a direction guess.
// Assumes: W >= 1; RST_VAL fits in W bits.
module gcp_sat_ctr #(
    parameter int unsigned W       = gcp_pkg::GCP_CTR_W,
    parameter logic [W-1:0] RST_VAL = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              train,
    input  gcp_pkg::gcp_dir_e dir,
    output logic [W-1:0]      value
);

    localparam logic [W-1:0] TOP = '1;
    localparam logic [W-1:0] BOT = '0;

    // Step toward the outcome, holding at either end of the range
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= RST_VAL;
        end else if (train) begin
            if (dir == gcp_pkg::DIR_TAKEN) begin
                if (value != TOP) value <= value + 1'b1;
            end else begin
                if (value != BOT) value <= value - 1'b1;
            end
        end
    end

endmodule

// File: rtl/gcorr_predictor.sv
// Global-correlating direction predictor. Address bits choose an entry,
// and the shared history chooses one counter inside it. The lookup is
// combinational from stored state. A training event changes one counter
// and the history at the next edge.
// Assumes: the caller returns the history it was given at lookup time.
module gcorr_predictor #(
    parameter int unsigned PC_W      = gcp_pkg::GCP_PC_W,
    parameter int unsigned IDX_LSB   = gcp_pkg::GCP_IDX_LSB,
    parameter int unsigned ADDR_BITS = gcp_pkg::GCP_ADDR_BITS,
    parameter int unsigned HIST_W    = gcp_pkg::GCP_HIST_W,
    parameter int unsigned CTR_W     = gcp_pkg::GCP_CTR_W,
    parameter logic [CTR_W-1:0] CTR_RST = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   pred_pc,
    output logic              pred_taken,
    output logic [HIST_W-1:0] pred_hist,
    input  logic              upd_valid,
    input  logic [PC_W-1:0]   upd_pc,
    input  logic              upd_taken,
    input  logic [HIST_W-1:0] upd_hist
);

    localparam int unsigned IDX_W   = ADDR_BITS + HIST_W;
    localparam int unsigned NUM_CTR = 1 << IDX_W;

    logic [IDX_W-1:0]  rd_idx;
    logic [IDX_W-1:0]  wr_idx;
    logic [CTR_W-1:0]  ctr_val [NUM_CTR];
    gcp_pkg::gcp_dir_e upd_dir;

    // Map the raw outcome bit to the direction type
    assign upd_dir = upd_taken ? gcp_pkg::DIR_TAKEN : gcp_pkg::DIR_NOT_TAKEN;

    gcp_index #(
        .PC_W(PC_W), .IDX_LSB(IDX_LSB), .ADDR_BITS(ADDR_BITS), .HIST_W(HIST_W)
    ) i_rd_index (
        .pc(pred_pc), .hist(pred_hist), .idx(rd_idx)
    );

    gcp_index #(
        .PC_W(PC_W), .IDX_LSB(IDX_LSB), .ADDR_BITS(ADDR_BITS), .HIST_W(HIST_W)
    ) i_wr_index (
        .pc(upd_pc), .hist(upd_hist), .idx(wr_idx)
    );

    gcp_ghr #(.HIST_W(HIST_W)) i_ghr (
        .clk(clk), .rst_n(rst_n), .shift_en(upd_valid),
        .dir(upd_dir), .hist(pred_hist)
    );

    // One counter cell per index; only the addressed one trains
    for (genvar g = 0; g < NUM_CTR; g++) begin : g_cell
        logic hit;
        assign hit = upd_valid && (wr_idx == IDX_W'(g));
        gcp_sat_ctr #(.W(CTR_W), .RST_VAL(CTR_RST)) i_ctr (
            .clk(clk), .rst_n(rst_n), .train(hit),
            .dir(upd_dir), .value(ctr_val[g])
        );
    end

    // Guess is the top bit of the addressed counter
    assign pred_taken = ctr_val[rd_idx][CTR_W-1];

endmodule

// File: rtl/gcp_checker.sv
// Port-level properties of the predictor, attached through bind.
// Assumes: synchronous active-low reset on rst_n.
module gcp_checker #(
    parameter int unsigned PC_W   = 32,
    parameter int unsigned HIST_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PC_W-1:0]   pred_pc,
    input logic              pred_taken,
    input logic [HIST_W-1:0] pred_hist,
    input logic              upd_valid,
    input logic              upd_taken
);

    logic was_in_reset = 1'b0;

    // Outputs are cleared on the edge after reset was sampled
    always @(posedge clk) begin
        if (was_in_reset) begin
            assert_reset_state_R1: assert (pred_hist == '0 && !pred_taken)
                else $error("reset state wrong");
        end
        was_in_reset <= !rst_n;
    end

    // The history shifts in the resolved outcome
    assert_hist_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> pred_hist == {$past(pred_hist[HIST_W-2:0]), $past(upd_taken)});

    // With no training the history holds
    assert_hist_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(pred_hist));

    // With no training and the same PC, the guess holds
    assert_guess_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> ($stable(pred_pc) -> $stable(pred_taken)));

endmodule

bind gcorr_predictor gcp_checker #(.PC_W(PC_W), .HIST_W(HIST_W)) i_gcp_checker (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
    .pred_hist(pred_hist), .upd_valid(upd_valid), .upd_taken(upd_taken)
);

// File: tb/test_gcorr_predictor.sv
// Scoreboard bench: the driver pushes expected results, the monitor compares.
module test_gcorr_predictor;

    typedef struct {
        logic       taken;
        logic [1:0] hist;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pred_pc = '0;
    logic        pred_taken;
    logic [1:0]  pred_hist;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [1:0]  upd_hist = '0;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    int   mdl_ctr[64];
    int   mdl_ghr = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #5 clk = ~clk;

    gcorr_predictor i_gcorr_predictor (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
        .pred_hist(pred_hist), .upd_valid(upd_valid), .upd_pc(upd_pc),
        .upd_taken(upd_taken), .upd_hist(upd_hist)
    );

    function automatic int idx_of(logic [31:0] pc, int h);
        return (int'(pc[5:2]) << 2) | (h & 3);
    endfunction

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 64; i++) mdl_ctr[i] = 1;
        mdl_ghr = 0;
    endtask

    // One cycle: drive, record the expectation, then advance the model
    task automatic step(input logic v, input logic [31:0] ppc, input logic [31:0] upc,
                        input logic t, input logic [1:0] uh, input string tag);
        exp_t e;
        int   k;
        @(negedge clk);
        pred_pc = ppc; upd_valid = v; upd_pc = upc; upd_taken = t; upd_hist = uh;
        e.taken = (mdl_ctr[idx_of(ppc, mdl_ghr)] >= 2);
        e.hist  = 2'(mdl_ghr);
        e.tag   = tag;
        q.push_back(e);
        if (v) begin
            k = idx_of(upc, int'(uh));
            if (t && mdl_ctr[k] < 3) mdl_ctr[k]++;
            else if (!t && mdl_ctr[k] > 0) mdl_ctr[k]--;
            mdl_ghr = ((mdl_ghr << 1) | int'(t)) & 3;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; upd_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // Monitor: compare outputs away from the clock edge
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #3;
            if (q.size() > 0) begin
                e = q.pop_front();
                n_chk++;
                if (pred_taken !== e.taken) begin
                    n_fail++;
                    $display("FAIL %s pred_taken actual=%b expected=%b", e.tag, pred_taken, e.taken);
                end
                n_chk++;
                if (pred_hist !== e.hist) begin
                    n_fail++;
                    $display("FAIL %s pred_hist actual=%b expected=%b", e.tag, pred_hist, e.hist);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #2000000;
        n_fail++; n_chk++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: every entry guesses not-taken with a clear history
        for (int i = 0; i < 16; i++) step(1'b0, 32'(i << 2), '0, 1'b0, 2'd0, "R1");
        // R3: train one counter up past saturation
        for (int i = 0; i < 5; i++) step(1'b1, 32'h14, 32'h14, 1'b1, 2'd0, "R3");
        step(1'b0, 32'h14, '0, 1'b0, 2'd0, "R3");
        // R4: train it down past the bottom
        for (int i = 0; i < 5; i++) step(1'b1, 32'h14, 32'h14, 1'b0, 2'd0, "R4");
        step(1'b0, 32'h14, '0, 1'b0, 2'd0, "R4");
        // R5: one counter of entry 3 taken, then read all four histories
        step(1'b1, 32'hC, 32'hC, 1'b1, 2'd2, "R5");
        step(1'b1, 32'hC, 32'hC, 1'b1, 2'd2, "R5");
        for (int h = 0; h < 4; h++) begin
            step(1'b1, 32'hC, 32'h3C, h[1], 2'd1, "R5");
            step(1'b1, 32'hC, 32'h3C, h[0], 2'd1, "R5");
            step(1'b0, 32'hC, '0, 1'b0, 2'd0, "R5");
        end
        // R6: history shift patterns
        step(1'b1, 32'h0, 32'h40, 1'b1, 2'd0, "R6");
        step(1'b1, 32'h0, 32'h40, 1'b0, 2'd0, "R6");
        step(1'b1, 32'h0, 32'h40, 1'b1, 2'd0, "R6");
        step(1'b0, 32'h0, 32'h0, 1'b0, 2'd0, "R6");
        // R7: train with a history differing from the live one
        for (int i = 0; i < 3; i++) step(1'b1, 32'h20, 32'h20, 1'b1, 2'd3, "R7");
        for (int h = 0; h < 4; h++) step(1'b0, 32'h20 | 32'(h), '0, 1'b0, 2'd0, "R7");
        // R8: train and look up the same counter in one cycle
        step(1'b1, 32'h28, 32'h28, 1'b1, pred_hist, "R8");
        step(1'b1, 32'h28, 32'h28, 1'b1, 2'(mdl_ghr), "R8");
        step(1'b1, 32'h28, 32'h28, 1'b0, 2'(mdl_ghr), "R8");
        step(1'b0, 32'h28, '0, 1'b0, 2'd0, "R8");
        // R9: idle cycles with junk on the training port
        for (int i = 0; i < 12; i++) step(1'b0, 32'(i << 2), rnd(), rnd() [0], 2'(rnd()), "R9");
        // R10: upper and lower PC noise
        for (int i = 0; i < 40; i++) begin
            logic [31:0] r;
            r = rnd();
            step(r[7], rnd(), rnd(), r[9], 2'(r[11:10]), "R10");
        end
        // R2: mixed traffic with realistic history hand-back
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = rnd();
            step(r[0] | r[1], 32'(r[15:12]) << 2, 32'(r[19:16]) << 2, r[20] | r[21],
                 r[2] ? 2'(mdl_ghr) : 2'(r[23:22]), "R2");
        end
        // R1: mid-run reset clears all trained state
        do_reset();
        for (int i = 0; i < 16; i++) step(1'b0, 32'(i << 2), '0, 1'b0, 2'd0, "R1");
        @(negedge clk);
        upd_valid = 1'b0;
        while (q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule